// File: doc/BRIEF.md
# Barrel shifter with carry-out

This block is the combinational shift stage of an operand datapath. It takes a data word, a shift amount that has already been decoded to a plain count, a shift kind and the current carry flag. It returns the shifted word together with the carry bit that a later flag unit may write back. Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag.

The count is taken in full, so any value up to the largest the amount port can carry gives a defined result. The carry follows fixed rules at a count of zero, at exactly the word width, and above it. Rotation uses the count modulo the word width, but a nonzero count that is a multiple of the width still yields a fresh carry. The block has no clock and no state: outputs follow inputs within the same cycle.

Top module: `barrel_shifter_cout`

## Requirements
- R1: For kinds 0 to 3 (left, logical right, arithmetic right, rotate), a count of 0 returns the data word unchanged and carry_o equals carry_i.
- R2: Kind 0 (logical left) with count n from 1 to DATA_W returns the word moved up n places with zeros entering at bit 0 (all zeros at n = DATA_W); carry_o is data bit DATA_W-n.
- R3: Kinds 0 and 1 with a count above DATA_W return an all-zero word and carry_o = 0.
- R4: Kind 1 (logical right) with count n from 1 to DATA_W returns the word moved down n places with zeros entering at the top (all zeros at n = DATA_W); carry_o is data bit n-1.
- R5: Kind 2 (arithmetic right) with count n from 1 to DATA_W moves the word down n places filling with the old top bit, carry_o being bit n-1; above DATA_W the word is all copies of the top bit and carry_o is the top bit.
- R6: Kind 3 (rotate right) with a nonzero count rotates by the count modulo DATA_W, and carry_o equals the top bit of the returned word, also when the reduced count is 0.
- R7: Kind 4 (rotate through carry) ignores the count, returns {carry_i, data[DATA_W-1:1]} and carry_o is data bit 0.
- R8: Kinds 5, 6 and 7 return the data word unchanged with carry_o equal to carry_i, for any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | DATA_W (32) | Word to be shifted |
| amount_i | input | AMT_W (8) | Decoded shift count |
| kind_i | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W (32) | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
Since the block holds no state, a fault in any shift stage or in the count decode shows at the ports in the same cycle as the stimulus that reaches it. A wrong stage select corrupts result_o only for counts with that bit set, so counts 1, 31, 32, 33 and 255 are applied to every kind to touch each stage and each carry rule boundary. A fault in the over-range decode is seen only at counts above the width, where the word would leak through instead of clearing or sign-filling; a carry taken from the wrong edge shows on carry_o alone while result_o stays right, so both outputs are compared on every vector.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [2:0] {
      SK_LEFT  = 3'd0,
      SK_LRIGHT = 3'd1,
      SK_ARIGHT = 3'd2,
      SK_ROT   = 3'd3,
      SK_ROTC  = 3'd4
   } shift_kind_e;

endpackage

// File: rtl/bshift_linear.sv
// Shared right-shifting core for left, logical right and arithmetic right.
// Left shifts are done by reversing the word on entry and on exit.
module bshift_linear #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic              left_i,
   input  logic              arith_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   localparam int LOG_W = $clog2(DATA_W);

   logic [DATA_W-1:0] src_rev;
   logic [DATA_W-1:0] oriented;
   logic [DATA_W-1:0] moved;
   logic [DATA_W-1:0] moved_rev;
   logic [DATA_W-1:0] edge_word;
   logic [AMT_W-1:0]  amt_less1;
   logic [LOG_W-1:0]  step;
   logic              fill;
   logic              beyond;
   logic              is_zero;
   logic              edge_carry;
   logic [DATA_W-1:0] stg [LOG_W+1];

   // Count minus one: counts 1..DATA_W map onto 0..DATA_W-1 in the low bits,
   // anything larger sets an upper bit.
   assign amt_less1 = amount_i - AMT_W'(1);
   assign step      = amt_less1[LOG_W-1:0];
   assign is_zero   = (amount_i == '0);
   assign beyond    = (amt_less1[AMT_W-1:LOG_W] != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
      assign src_rev[i] = src_i[DATA_W-1-i];
   end

   assign oriented = left_i ? src_rev : src_i;
   assign fill     = arith_i & ~left_i & src_i[DATA_W-1];

   assign stg[0] = oriented;
   for (genvar k = 0; k < LOG_W; k++) begin : g_stage
      localparam int SH = 1 << k;
      assign stg[k+1] = step[k] ? {{SH{fill}}, stg[k][DATA_W-1:SH]} : stg[k];
   end

   // The final fixed one-place step exposes the carry bit directly.
   assign edge_word  = {fill, stg[LOG_W][DATA_W-1:1]};
   assign edge_carry = stg[LOG_W][0];

   always_comb begin
      if (beyond) begin
         moved   = {DATA_W{fill}};
      end else begin
         moved   = edge_word;
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
      assign moved_rev[i] = moved[DATA_W-1-i];
   end

   always_comb begin
      if (is_zero) begin
         result_o = src_i;
         carry_o  = carry_i;
      end else begin
         result_o = left_i ? moved_rev : moved;
         if (beyond) begin
            carry_o = fill;
         end else begin
            carry_o = edge_carry;
         end
      end
   end

endmodule

// File: rtl/bshift_rotate.sv
// Rotate right by count modulo DATA_W, or one place through the carry flag.
module bshift_rotate #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic              extend_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   localparam int LOG_W = $clog2(DATA_W);

   logic [LOG_W-1:0]  step;
   logic              nonzero;
   logic [DATA_W-1:0] stg [LOG_W+1];

   assign step    = amount_i[LOG_W-1:0];
   assign nonzero = |amount_i;

   assign stg[0] = src_i;
   for (genvar k = 0; k < LOG_W; k++) begin : g_stage
      localparam int SH = 1 << k;
      assign stg[k+1] = step[k] ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]} : stg[k];
   end

   always_comb begin
      if (extend_i) begin
         result_o = {carry_i, src_i[DATA_W-1:1]};
         carry_o  = src_i[0];
      end else if (nonzero) begin
         result_o = stg[LOG_W];
         carry_o  = stg[LOG_W][DATA_W-1];
      end else begin
         result_o = src_i;
         carry_o  = carry_i;
      end
   end

endmodule

// File: rtl/barrel_shifter_cout.sv
module barrel_shifter_cout #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic [2:0]        kind_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   import bshift_pkg::*;

   localparam int LOG_W = $clog2(DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (AMT_W <= LOG_W) begin : g_bad_amt
      $error("AMT_W must be wide enough to express DATA_W");
   end

   shift_kind_e       kind;
   logic [DATA_W-1:0] lin_res;
   logic [DATA_W-1:0] rot_res;
   logic              lin_c;
   logic              rot_c;
   logic              use_left;
   logic              use_arith;
   logic              use_ext;

   assign kind      = shift_kind_e'(kind_i);
   assign use_left  = (kind == SK_LEFT);
   assign use_arith = (kind == SK_ARIGHT);
   assign use_ext   = (kind == SK_ROTC);

   bshift_linear #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lin (
      .src_i    (src_i),
      .amount_i (amount_i),
      .left_i   (use_left),
      .arith_i  (use_arith),
      .carry_i  (carry_i),
      .result_o (lin_res),
      .carry_o  (lin_c)
   );

   bshift_rotate #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
      .src_i    (src_i),
      .amount_i (amount_i),
      .extend_i (use_ext),
      .carry_i  (carry_i),
      .result_o (rot_res),
      .carry_o  (rot_c)
   );

   always_comb begin
      unique case (kind)
         SK_LEFT, SK_LRIGHT, SK_ARIGHT: begin
            result_o = lin_res;
            carry_o  = lin_c;
         end
         SK_ROT, SK_ROTC: begin
            result_o = rot_res;
            carry_o  = rot_c;
         end
         default: begin
            result_o = src_i;
            carry_o  = carry_i;
         end
      endcase
   end

endmodule

// File: rtl/bshift_checker.sv
module bshift_checker #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input logic [DATA_W-1:0] src_i,
   input logic [AMT_W-1:0]  amount_i,
   input logic [2:0]        kind_i,
   input logic              carry_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o
);
   always_comb begin
      if (kind_i <= 3'd3 && amount_i == '0) begin
         p_zero_pass_r1: assert (result_o == src_i && carry_o == carry_i)
            else $error("R1 zero count did not pass through");
      end
      if (kind_i <= 3'd1 && amount_i > AMT_W'(DATA_W)) begin
         p_over_clear_r3: assert (result_o == '0 && carry_o == 1'b0)
            else $error("R3 over-range logical shift not cleared");
      end
      if (kind_i == 3'd2 && amount_i >= AMT_W'(DATA_W)) begin
         p_sign_fill_r5: assert (result_o == {DATA_W{src_i[DATA_W-1]}} &&
                                 carry_o == src_i[DATA_W-1])
            else $error("R5 arithmetic over-range not sign filled");
      end
      if (kind_i == 3'd3 && amount_i != '0) begin
         p_rot_carry_r6: assert (carry_o == result_o[DATA_W-1])
            else $error("R6 rotate carry not top bit");
      end
      if (kind_i == 3'd4) begin
         p_ext_rot_r7: assert (result_o[DATA_W-1] == carry_i && carry_o == src_i[0] &&
                               result_o[DATA_W-2:0] == src_i[DATA_W-1:1])
            else $error("R7 rotate through carry wrong");
      end
      if (kind_i >= 3'd5) begin
         p_unused_pass_r8: assert (result_o == src_i && carry_o == carry_i)
            else $error("R8 unused kind altered data");
      end
   end
endmodule

bind barrel_shifter_cout bshift_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
   .src_i    (src_i),
   .amount_i (amount_i),
   .kind_i   (kind_i),
   .carry_i  (carry_i),
   .result_o (result_o),
   .carry_o  (carry_o)
);

// File: tb/sim_barrel_shifter_cout.sv
module sim_barrel_shifter_cout;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NVEC = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] src;
   logic [AW-1:0] amt;
   logic [2:0]    kind;
   logic          cin;
   logic [DW-1:0] res;
   logic          cout;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   barrel_shifter_cout #(.DATA_W(DW), .AMT_W(AW)) u0 (
      .src_i(src), .amount_i(amt), .kind_i(kind), .carry_i(cin),
      .result_o(res), .carry_o(cout)
   );

   // {kind, count, data, carry in, expected word, expected carry}
   localparam logic [76:0] VEC [NVEC] = '{
      {3'd0, 8'd1,   32'h80000001, 1'b0, 32'h00000002, 1'b1}, // R2
      {3'd1, 8'd1,   32'h80000001, 1'b0, 32'h40000000, 1'b1}, // R4
      {3'd2, 8'd4,   32'h80000010, 1'b0, 32'hF8000001, 1'b0}, // R5
      {3'd3, 8'd8,   32'h12345678, 1'b0, 32'h78123456, 1'b0}, // R6
      {3'd3, 8'd32,  32'h80000000, 1'b0, 32'h80000000, 1'b1}, // R6 multiple of width
      {3'd4, 8'd9,   32'h00000001, 1'b1, 32'h80000000, 1'b1}, // R7
      {3'd0, 8'd32,  32'h00000001, 1'b0, 32'h00000000, 1'b1}, // R2 at width
      {3'd1, 8'd33,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0}, // R3
      {3'd2, 8'd255, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1}, // R5 far over
      {3'd5, 8'd3,   32'hA5A5A5A5, 1'b1, 32'hA5A5A5A5, 1'b1}, // R8
      {3'd0, 8'd0,   32'hDEADBEEF, 1'b1, 32'hDEADBEEF, 1'b1}, // R1
      {3'd3, 8'd33,  32'h00000003, 1'b0, 32'h80000001, 1'b1}  // R6 reduced
   };

   function automatic string req_tag(input logic [2:0] k, input int n);
      if (k >= 3'd5) return "R8";
      if (k == 3'd4) return "R7";
      if (n == 0) return "R1";
      if (k == 3'd3) return "R6";
      if (k == 3'd2) return "R5";
      if (n > DW) return "R3";
      if (k == 3'd0) return "R2";
      return "R4";
   endfunction

   // Reference model written bit by bit from the requirements.
   task automatic model(input logic [2:0] k, input int n, input logic [DW-1:0] d,
                        input logic ci, output logic [DW-1:0] r, output logic co);
      r  = d;
      co = ci;
      if (k == 3'd4) begin
         r  = {ci, d[DW-1:1]};
         co = d[0];
      end else if (k <= 3'd3 && n != 0) begin
         for (int i = 0; i < DW; i++) begin
            int j;
            case (k)
               3'd0: begin j = i - n; r[i] = (j >= 0) ? d[j] : 1'b0; end
               3'd1: begin j = i + n; r[i] = (j < DW) ? d[j] : 1'b0; end
               3'd2: begin j = i + n; r[i] = (j < DW) ? d[j] : d[DW-1]; end
               default: begin j = (i + n) % DW; r[i] = d[j]; end
            endcase
         end
         case (k)
            3'd0: co = (n <= DW) ? d[DW-n] : 1'b0;
            3'd1: co = (n <= DW) ? d[n-1] : 1'b0;
            3'd2: co = (n <= DW) ? d[n-1] : d[DW-1];
            default: co = r[DW-1];
         endcase
      end
   endtask

   task automatic apply_check(input logic [2:0] k, input logic [AW-1:0] n,
                              input logic [DW-1:0] d, input logic ci,
                              input logic [DW-1:0] er, input logic ec, input string tag);
      @(negedge clk);
      kind = k; amt = n; src = d; cin = ci;
      #2;
      n_checks++;
      if (res !== er || cout !== ec) begin
         n_fails++;
         $display("FAIL %s kind=%0d count=%0d data=%h: got %h/%b expected %h/%b",
                  tag, k, n, d, res, cout, er, ec);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] er;
      logic          ec;
      int            amts [8];
      logic [DW-1:0] datas [4];
      amts  = '{0, 1, 7, 16, 31, 32, 33, 255};
      datas = '{32'h80000001, 32'h7FFFFFFE, 32'hDEADBEEF, 32'h00000000};

      src = '0; amt = '0; kind = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Reset state: idle zero inputs give zero word and zero carry (R1)
      apply_check(3'd0, 8'd0, '0, 1'b0, '0, 1'b0, "R1");

      // Table of hand-computed vectors
      for (int v = 0; v < NVEC; v++) begin
         logic [76:0] e;
         e = VEC[v];
         apply_check(e[76:74], e[73:66], e[65:34], e[33], e[32:1], e[0],
                     req_tag(e[76:74], int'(e[73:66])));
      end

      // Sweep of every kind over the boundary counts against the model
      for (int k = 0; k < 8; k++) begin
         for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 4; s++) begin
               for (int c = 0; c < 2; c++) begin
                  model(3'(k), amts[a], datas[s], 1'(c), er, ec);
                  apply_check(3'(k), 8'(amts[a]), datas[s], 1'(c), er, ec,
                              req_tag(3'(k), amts[a]));
               end
            end
         end
      end

      // Directed corners
      apply_check(3'd0, 8'd31, 32'h00000003, 1'b0, 32'h80000000, 1'b1, "R2");
      apply_check(3'd1, 8'd32, 32'h80000000, 1'b0, 32'h00000000, 1'b1, "R4");
      apply_check(3'd0, 8'd255, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, "R3");
      apply_check(3'd2, 8'd32, 32'h7FFFFFFF, 1'b1, 32'h00000000, 1'b0, "R5");
      apply_check(3'd3, 8'd64, 32'h00000001, 1'b1, 32'h00000001, 1'b0, "R6");
      apply_check(3'd4, 8'd0, 32'h00000002, 1'b0, 32'h00000001, 1'b0, "R7");
      apply_check(3'd7, 8'd255, 32'h0F0F0F0F, 1'b0, 32'h0F0F0F0F, 1'b0, "R8");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule